// File: doc/BRIEF.md
# Test Control Register File

This block is the register file a host reaches through a simple word-addressed register port to drive a dual-channel storage test system. It decodes the address into six regions: one block per channel (two channels), a read-only window onto the identify memory, a read/write window onto the custom-command memory, a custom-command queue and a small shared area. Each channel keeps its own start address, transfer length, pattern selector, rate setting and command code. These drive the storage controller and the pattern engines directly.

Writing a channel's command register turns a legal code into a one-cycle request pulse toward the controller. Channel 0 accepts every defined command. Channel 1 accepts only write and read. Reads pass through two registered multiplexer levels and return with a fixed latency of two clock cycles. The memories sit outside the block: it presents a word address and a write strobe, and takes back each memory's registered read data.

The register port carries full 32-bit words only and has no byte enables. Every write replaces the whole field it addresses. `regAddr` is a word address, that is, the byte offset divided by four. The byte offsets below are given for readability.

Top module: `testRegFile`

## Requirements
- R1: While reset is held and after it is released, every parameter output, every command pulse, the submission queue, the timeout word and `regRdValid` are zero.
- R2: Channel control fields are written at byte offsets 0x00 (start address bits 31:0), 0x04 (bits 47:32 from data 15:0), 0x08 and 0x0C (length, same split), 0x14 (pattern, data 2:0) and 0x18 (rate, data 6:0). Channel 1 uses the same offsets plus 0x200. A written value appears on the outputs one cycle after the write, and the other channel is unchanged.
- R3: A write of a legal code to a channel's command offset 0x10 raises that channel's `chCmdReq` bit for exactly one cycle, starting one cycle after the write, with `chCmdCode` holding the code. Codes: 000 identify, 001 shutdown, 010 write, 011 read, 100 health log, 110 flush.
- R4: On channel 0, the reserved codes 101 and 111 produce no pulse and leave `chCmdCode` unchanged.
- R5: Channel 1 pulses only for 010 and 011. Any other code produces no pulse and leaves its `chCmdCode` unchanged.
- R6: `regRdValid` is high for exactly one cycle, two cycles after a cycle in which `regRdReq` is high, and `regRdData` holds the result in that cycle.
- R7: Channel status reads at byte offset 0x100 (channel 1: 0x300) return bit 0 busy, bit 1 controller error and bit 2 verify fail. Offset 0x104 (0x304) returns the channel's 32-bit error type.
- R8: Write-only locations (channel control, submission queue, timeout) and unmapped addresses read as zero.
- R9: The identify window (0x2000–0x3FFF) returns the identify memory's data for `memWordAddr` = word address bits 10:0. Writes to this window raise no memory write strobe.
- R10: A write to the custom window (0x4000–0x5FFF) raises `ctmWrEn` in the same cycle, with `ctmWrData` and `memWordAddr` set from the write. Reads in this window return the custom memory's data.
- R11: Writes to 0x6000–0x603C set submission entry (byte offset − 0x6000)/4 and no other entry. Reads of 0x6100–0x610C return completion entries 0–3. Writes to the completion range change nothing.
- R12: A write to 0x8000 sets `timeoutSet`, and writes elsewhere in the shared area leave it unchanged. A read of 0x8100 returns link-up in bit 0, speed in bits 3:2, width in bits 7:4 and training state in bits 12:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 14 | Word address (byte offset / 4) |
| regWrData | input | 32 | Write data |
| regRdReq | input | 1 | Read request |
| regRdData | output | 32 | Read data |
| regRdValid | output | 1 | Read data valid |
| chStartAddr | output | 2x48 | Per-channel start address |
| chLen | output | 2x48 | Per-channel transfer length |
| chCmdCode | output | 2x3 | Per-channel last accepted command code |
| chCmdReq | output | 2 | Per-channel one-cycle command request |
| chPattern | output | 2x3 | Per-channel pattern selector |
| chRate | output | 2x7 | Per-channel rate setting |
| chBusy | input | 2 | Per-channel busy status |
| chError | input | 2 | Per-channel controller error |
| chVerifyFail | input | 2 | Per-channel data-verification fail |
| chErrType | input | 2x32 | Per-channel error type word |
| memWordAddr | output | 11 | Word address into identify and custom memories |
| idenRdData | input | 32 | Identify memory registered read data |
| ctmWrEn | output | 1 | Custom memory write strobe |
| ctmWrData | output | 32 | Custom memory write data |
| ctmRdData | input | 32 | Custom memory registered read data |
| ctmSubmQ | output | 16x32 | Custom submission queue entries |
| ctmCompQ | input | 4x32 | Custom completion queue entries |
| timeoutSet | output | 32 | Controller timeout setting |
| linkUp | input | 1 | Link up status |
| linkSpeed | input | 2 | Link speed |
| linkWidth | input | 4 | Link width |
| ltssmState | input | 5 | Link training state |

## Verification
Results fall due at three fixed distances from a stimulus. The memory write strobe, data and address follow the inputs within the same cycle. Parameter fields and the command pulse change at the first clock edge after the write is sampled. Read data and `regRdValid` arrive at the second edge after the request is sampled. The bench drives inputs on falling edges and reads results on later falling edges: the write-cycle outputs shortly after driving, the parameters and pulse one falling edge after the write, and the read result two falling edges after the request. It also samples one cycle early and one cycle late, so a shifted pulse or valid is caught.

// File: rtl/trfPkg.sv
package trfPkg;
  localparam int NUM_CH   = 2;
  localparam int CH_IW    = $clog2(NUM_CH);
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 14;
  localparam int PARAM_W  = 48;
  localparam int HI_W     = PARAM_W - DATA_W;
  localparam int CMD_W    = 3;
  localparam int PATT_W   = 3;
  localparam int RATE_W   = 7;
  localparam int SUBQ_N   = 16;
  localparam int SUBQ_IW  = $clog2(SUBQ_N);
  localparam int COMPQ_N  = 4;
  localparam int COMPQ_IW = $clog2(COMPQ_N);
  localparam int MEM_AW   = 11;

  localparam logic [CMD_W-1:0] CMD_WRITE = 3'b010;
  localparam logic [CMD_W-1:0] CMD_READ  = 3'b011;
  localparam logic [CMD_W-1:0] CMD_RSV_A = 3'b101;
  localparam logic [CMD_W-1:0] CMD_RSV_B = 3'b111;

  typedef enum logic [2:0] {
    RG_NONE, RG_CHAN, RG_IDEN, RG_CTM, RG_QUEUE, RG_SHARED
  } region_e;

  typedef enum logic [2:0] {
    CF_ADRL, CF_ADRH, CF_LENL, CF_LENH, CF_CMD, CF_PATT, CF_RATE, CF_NONE
  } ctlField_e;

  typedef struct packed {
    logic [NUM_CH-1:0]  chWr;
    ctlField_e          field;
    logic [NUM_CH-1:0]  cmdOk;
    logic               subqWr;
    logic [SUBQ_IW-1:0] subqIdx;
    logic               toutWr;
    logic               rdCap1;
    logic               rdCap2;
    region_e            rdRegion;
    logic [CH_IW-1:0]   rdCh;
  } strobe_t;

  function automatic logic cmdLegal(input int ch, input logic [CMD_W-1:0] code);
    if (ch == 0) return !(code == CMD_RSV_A || code == CMD_RSV_B);
    return (code == CMD_WRITE) || (code == CMD_READ);
  endfunction
endpackage

// File: rtl/trfCtrl.sv
module trfCtrl
  import trfPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CMD_W-1:0]  wrCode,
  input  logic              regRdReq,
  output strobe_t           str,
  output logic              regRdValid,
  output logic              ctmWrEn,
  output logic [MEM_AW-1:0] memWordAddr
);
  region_e          region;
  logic [CH_IW-1:0] chIdx;
  ctlField_e        field;
  logic [NUM_CH-1:0] chWr;
  logic [NUM_CH-1:0] cmdOk;

  logic             rdStage1Q;
  logic             rdValidQ;
  region_e          rdRegionQ;
  logic [CH_IW-1:0] rdChQ;

  always_comb begin
    region = RG_NONE;
    chIdx  = '0;
    if (regAddr[13]) begin
      region = RG_SHARED;
    end else begin
      unique case (regAddr[12:11])
        2'b01:   region = RG_IDEN;
        2'b10:   region = RG_CTM;
        2'b11:   region = RG_QUEUE;
        default: begin
          if (regAddr[10:8] == 3'b000) begin
            region = RG_CHAN;
            chIdx  = regAddr[7 +: CH_IW];
          end
        end
      endcase
    end
  end

  always_comb begin
    field = CF_NONE;
    if (region == RG_CHAN && !regAddr[6] && regAddr[5:3] == 3'b000) begin
      field = ctlField_e'(regAddr[2:0]);
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : gChDec
    assign chWr[c]  = regWrEn && (region == RG_CHAN) && (chIdx == CH_IW'(c))
                      && (field != CF_NONE);
    assign cmdOk[c] = chWr[c] && (field == CF_CMD) && cmdLegal(c, wrCode);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdStage1Q <= 1'b0;
      rdValidQ  <= 1'b0;
      rdRegionQ <= RG_NONE;
      rdChQ     <= '0;
    end else begin
      rdStage1Q <= regRdReq;
      rdValidQ  <= rdStage1Q;
      if (regRdReq) begin
        rdRegionQ <= region;
        rdChQ     <= chIdx;
      end
    end
  end

  always_comb begin
    str          = '0;
    str.chWr     = chWr;
    str.field    = field;
    str.cmdOk    = cmdOk;
    str.subqWr   = regWrEn && (region == RG_QUEUE) && (regAddr[10:4] == 7'd0);
    str.subqIdx  = regAddr[SUBQ_IW-1:0];
    str.toutWr   = regWrEn && (region == RG_SHARED) && (regAddr[12:0] == 13'd0);
    str.rdCap1   = regRdReq;
    str.rdCap2   = rdStage1Q;
    str.rdRegion = rdRegionQ;
    str.rdCh     = rdChQ;
  end

  assign regRdValid  = rdValidQ;
  assign ctmWrEn     = regWrEn && (region == RG_CTM);
  assign memWordAddr = regAddr[MEM_AW-1:0];
endmodule

// File: rtl/trfData.sv
module trfData
  import trfPkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  strobe_t                         str,
  input  logic [ADDR_W-1:0]               regAddr,
  input  logic [DATA_W-1:0]               regWrData,
  output logic [DATA_W-1:0]               regRdData,
  output logic [NUM_CH-1:0][PARAM_W-1:0]  chStartAddr,
  output logic [NUM_CH-1:0][PARAM_W-1:0]  chLen,
  output logic [NUM_CH-1:0][CMD_W-1:0]    chCmdCode,
  output logic [NUM_CH-1:0]               chCmdReq,
  output logic [NUM_CH-1:0][PATT_W-1:0]   chPattern,
  output logic [NUM_CH-1:0][RATE_W-1:0]   chRate,
  input  logic [NUM_CH-1:0]               chBusy,
  input  logic [NUM_CH-1:0]               chError,
  input  logic [NUM_CH-1:0]               chVerifyFail,
  input  logic [NUM_CH-1:0][DATA_W-1:0]   chErrType,
  input  logic [DATA_W-1:0]               idenRdData,
  input  logic [DATA_W-1:0]               ctmRdData,
  output logic [SUBQ_N-1:0][DATA_W-1:0]   ctmSubmQ,
  input  logic [COMPQ_N-1:0][DATA_W-1:0]  ctmCompQ,
  output logic [DATA_W-1:0]               timeoutSet,
  input  logic                            linkUp,
  input  logic [1:0]                      linkSpeed,
  input  logic [3:0]                      linkWidth,
  input  logic [4:0]                      ltssmState
);
  localparam logic [8:0]  COMPQ_BASE = 9'h010;
  localparam logic [12:0] LINK_WORD  = 13'h0040;

  logic [NUM_CH-1:0][DATA_W-1:0] chWordQ;
  logic [DATA_W-1:0] queueWordQ;
  logic [DATA_W-1:0] sharedWordQ;
  logic [DATA_W-1:0] rdDataQ;
  logic [SUBQ_N-1:0][DATA_W-1:0] subqQ;
  logic [DATA_W-1:0] toutQ;

  for (genvar c = 0; c < NUM_CH; c++) begin : gCh
    logic [PARAM_W-1:0] addrQ;
    logic [PARAM_W-1:0] lenQ;
    logic [CMD_W-1:0]   codeQ;
    logic               reqQ;
    logic [PATT_W-1:0]  pattQ;
    logic [RATE_W-1:0]  rateQ;
    logic [DATA_W-1:0]  wordD;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        addrQ <= '0;
        lenQ  <= '0;
        codeQ <= '0;
        reqQ  <= 1'b0;
        pattQ <= '0;
        rateQ <= '0;
      end else begin
        reqQ <= str.cmdOk[c];
        if (str.chWr[c]) begin
          unique case (str.field)
            CF_ADRL: addrQ[DATA_W-1:0]       <= regWrData;
            CF_ADRH: addrQ[PARAM_W-1:DATA_W] <= regWrData[HI_W-1:0];
            CF_LENL: lenQ[DATA_W-1:0]        <= regWrData;
            CF_LENH: lenQ[PARAM_W-1:DATA_W]  <= regWrData[HI_W-1:0];
            CF_CMD:  if (str.cmdOk[c]) codeQ <= regWrData[CMD_W-1:0];
            CF_PATT: pattQ <= regWrData[PATT_W-1:0];
            CF_RATE: rateQ <= regWrData[RATE_W-1:0];
            default: ;
          endcase
        end
      end
    end

    // First mux level: word inside this channel's status block
    always_comb begin
      wordD = '0;
      if (regAddr[6] && regAddr[5:1] == 5'd0) begin
        wordD = regAddr[0] ? chErrType[c]
                           : {{(DATA_W-3){1'b0}}, chVerifyFail[c], chError[c], chBusy[c]};
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           chWordQ[c] <= '0;
      else if (str.rdCap1) chWordQ[c] <= wordD;
    end

    assign chStartAddr[c] = addrQ;
    assign chLen[c]       = lenQ;
    assign chCmdCode[c]   = codeQ;
    assign chCmdReq[c]    = reqQ;
    assign chPattern[c]   = pattQ;
    assign chRate[c]      = rateQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      subqQ <= '0;
      toutQ <= '0;
    end else begin
      if (str.subqWr) subqQ[str.subqIdx] <= regWrData;
      if (str.toutWr) toutQ <= regWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      queueWordQ  <= '0;
      sharedWordQ <= '0;
    end else if (str.rdCap1) begin
      queueWordQ  <= (regAddr[10:2] == COMPQ_BASE) ? ctmCompQ[regAddr[COMPQ_IW-1:0]] : '0;
      sharedWordQ <= (regAddr[12:0] == LINK_WORD)
                     ? {{(DATA_W-13){1'b0}}, ltssmState, linkWidth, linkSpeed, 1'b0, linkUp}
                     : '0;
    end
  end

  // Second mux level: pick the submodule recorded with the request
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdDataQ <= '0;
    end else if (str.rdCap2) begin
      unique case (str.rdRegion)
        RG_CHAN:   rdDataQ <= chWordQ[str.rdCh];
        RG_IDEN:   rdDataQ <= idenRdData;
        RG_CTM:    rdDataQ <= ctmRdData;
        RG_QUEUE:  rdDataQ <= queueWordQ;
        RG_SHARED: rdDataQ <= sharedWordQ;
        default:   rdDataQ <= '0;
      endcase
    end
  end

  assign regRdData  = rdDataQ;
  assign ctmSubmQ   = subqQ;
  assign timeoutSet = toutQ;
endmodule

// File: rtl/testRegFile.sv
module testRegFile
  import trfPkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            regWrEn,
  input  logic [ADDR_W-1:0]               regAddr,
  input  logic [DATA_W-1:0]               regWrData,
  input  logic                            regRdReq,
  output logic [DATA_W-1:0]               regRdData,
  output logic                            regRdValid,
  output logic [NUM_CH-1:0][PARAM_W-1:0]  chStartAddr,
  output logic [NUM_CH-1:0][PARAM_W-1:0]  chLen,
  output logic [NUM_CH-1:0][CMD_W-1:0]    chCmdCode,
  output logic [NUM_CH-1:0]               chCmdReq,
  output logic [NUM_CH-1:0][PATT_W-1:0]   chPattern,
  output logic [NUM_CH-1:0][RATE_W-1:0]   chRate,
  input  logic [NUM_CH-1:0]               chBusy,
  input  logic [NUM_CH-1:0]               chError,
  input  logic [NUM_CH-1:0]               chVerifyFail,
  input  logic [NUM_CH-1:0][DATA_W-1:0]   chErrType,
  output logic [MEM_AW-1:0]               memWordAddr,
  input  logic [DATA_W-1:0]               idenRdData,
  output logic                            ctmWrEn,
  output logic [DATA_W-1:0]               ctmWrData,
  input  logic [DATA_W-1:0]               ctmRdData,
  output logic [SUBQ_N-1:0][DATA_W-1:0]   ctmSubmQ,
  input  logic [COMPQ_N-1:0][DATA_W-1:0]  ctmCompQ,
  output logic [DATA_W-1:0]               timeoutSet,
  input  logic                            linkUp,
  input  logic [1:0]                      linkSpeed,
  input  logic [3:0]                      linkWidth,
  input  logic [4:0]                      ltssmState
);
  strobe_t str;

  trfCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .wrCode     (regWrData[CMD_W-1:0]),
    .regRdReq   (regRdReq),
    .str        (str),
    .regRdValid (regRdValid),
    .ctmWrEn    (ctmWrEn),
    .memWordAddr(memWordAddr)
  );

  trfData uData (
    .clk         (clk),
    .rstN        (rstN),
    .str         (str),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .regRdData   (regRdData),
    .chStartAddr (chStartAddr),
    .chLen       (chLen),
    .chCmdCode   (chCmdCode),
    .chCmdReq    (chCmdReq),
    .chPattern   (chPattern),
    .chRate      (chRate),
    .chBusy      (chBusy),
    .chError     (chError),
    .chVerifyFail(chVerifyFail),
    .chErrType   (chErrType),
    .idenRdData  (idenRdData),
    .ctmRdData   (ctmRdData),
    .ctmSubmQ    (ctmSubmQ),
    .ctmCompQ    (ctmCompQ),
    .timeoutSet  (timeoutSet),
    .linkUp      (linkUp),
    .linkSpeed   (linkSpeed),
    .linkWidth   (linkWidth),
    .ltssmState  (ltssmState)
  );

  assign ctmWrData = regWrData;
endmodule

// File: rtl/trfChecker.sv
module trfChecker
  import trfPkg::*;
(
  input logic                          clk,
  input logic                          rstN,
  input logic                          regWrEn,
  input logic [ADDR_W-1:0]             regAddr,
  input logic                          regRdReq,
  input logic                          regRdValid,
  input logic [NUM_CH-1:0][CMD_W-1:0]  chCmdCode,
  input logic [NUM_CH-1:0]             chCmdReq,
  input logic [NUM_CH-1:0][PATT_W-1:0] chPattern,
  input logic [NUM_CH-1:0][RATE_W-1:0] chRate,
  input logic                          ctmWrEn
);
  logic [1:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2) |-> (regRdValid == $past(regRdReq, 2))); // R6

  AST_CMD_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    chCmdReq[0] |-> ($past(regWrEn) && $past(regAddr) == 14'h0004)); // R3

  AST_CH0_NO_RESERVED: assert property (@(posedge clk) disable iff (!rstN)
    chCmdReq[0] |-> (chCmdCode[0] != 3'b101 && chCmdCode[0] != 3'b111)); // R4

  AST_CH1_RW_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    chCmdReq[1] |-> (chCmdCode[1] == 3'b010 || chCmdCode[1] == 3'b011)); // R5

  AST_PARAM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(regWrEn) |-> ($stable(chRate) && $stable(chPattern))); // R2

  AST_IDEN_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr[13:11] == 3'b001) |-> !ctmWrEn); // R9
endmodule

bind testRegFile trfChecker uChk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regRdReq  (regRdReq),
  .regRdValid(regRdValid),
  .chCmdCode (chCmdCode),
  .chCmdReq  (chCmdReq),
  .chPattern (chPattern),
  .chRate    (chRate),
  .ctmWrEn   (ctmWrEn)
);

// File: tb/tb_testRegFile.sv
module tb_testRegFile;
  import trfPkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [DATA_W-1:0] regWrData = '0;
  logic regRdReq = 1'b0;
  logic [DATA_W-1:0] regRdData;
  logic regRdValid;
  logic [NUM_CH-1:0][PARAM_W-1:0] chStartAddr, chLen;
  logic [NUM_CH-1:0][CMD_W-1:0] chCmdCode;
  logic [NUM_CH-1:0] chCmdReq;
  logic [NUM_CH-1:0][PATT_W-1:0] chPattern;
  logic [NUM_CH-1:0][RATE_W-1:0] chRate;
  logic [NUM_CH-1:0] chBusy, chError, chVerifyFail;
  logic [NUM_CH-1:0][DATA_W-1:0] chErrType;
  logic [MEM_AW-1:0] memWordAddr;
  logic [DATA_W-1:0] idenRdData = '0;
  logic [DATA_W-1:0] ctmRdData = '0;
  logic ctmWrEn;
  logic [DATA_W-1:0] ctmWrData;
  logic [SUBQ_N-1:0][DATA_W-1:0] ctmSubmQ;
  logic [COMPQ_N-1:0][DATA_W-1:0] ctmCompQ;
  logic [DATA_W-1:0] timeoutSet;
  logic linkUp;
  logic [1:0] linkSpeed;
  logic [3:0] linkWidth;
  logic [4:0] ltssmState;

  int nChecks = 0;
  int nErrors = 0;
  logic sawCtmWr;
  logic [DATA_W-1:0] sawCtmData;
  logic [MEM_AW-1:0] sawMemAddr;

  always #4 clk = ~clk;

  testRegFile dut (.*);

  // Memory models: registered read, one cycle
  always @(posedge clk) begin
    idenRdData <= 32'h1D00_0000 | {21'd0, memWordAddr};
    ctmRdData  <= 32'hC700_0000 | {21'd0, memWordAddr};
  end

  initial begin
    chBusy       = 2'b01;
    chError      = 2'b10;
    chVerifyFail = 2'b01;
    chErrType[0] = 32'hE0E0_0001;
    chErrType[1] = 32'hE1E1_0002;
    for (int k = 0; k < COMPQ_N; k++) ctmCompQ[k] = 32'hC000_0000 + k;
    linkUp = 1'b1; linkSpeed = 2'b11; linkWidth = 4'b0100; ltssmState = 5'h11;
  end

  // {tag, byte offset, expected data}
  localparam logic [63:0] RD_VEC [15] = '{
    {"R7", 16'h0100, 32'h0000_0005},
    {"R7", 16'h0104, 32'hE0E0_0001},
    {"R7", 16'h0300, 32'h0000_0002},
    {"R7", 16'h0304, 32'hE1E1_0002},
    {"R8", 16'h0000, 32'h0000_0000},
    {"R8", 16'h0108, 32'h0000_0000},
    {"R9", 16'h2010, 32'h1D00_0004},
    {"R9", 16'h3FFC, 32'h1D00_07FF},
    {"R10",16'h4020, 32'hC700_0008},
    {"R11",16'h6100, 32'hC000_0000},
    {"R11",16'h610C, 32'hC000_0003},
    {"R8", 16'h6000, 32'h0000_0000},
    {"R12",16'h8100, 32'h0000_114D},
    {"R8", 16'h8000, 32'h0000_0000},
    {"R8", 16'h1000, 32'h0000_0000}
  };

  task automatic chk(input logic [23:0] tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [15:0] byteOff, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = byteOff[15:2]; regWrData = d;
    #1;
    sawCtmWr = ctmWrEn; sawCtmData = ctmWrData; sawMemAddr = memWordAddr;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic doRead(input logic [15:0] byteOff, input logic [31:0] exp, input logic [23:0] tag);
    @(negedge clk);
    regAddr = byteOff[15:2]; regRdReq = 1'b1;
    @(negedge clk);
    regRdReq = 1'b0;
    chk("R6", {63'd0, regRdValid}, 64'd0);
    @(negedge clk);
    chk("R6", {63'd0, regRdValid}, 64'd1);
    chk(tag, {32'd0, regRdData}, {32'd0, exp});
    @(negedge clk);
    chk("R6", {63'd0, regRdValid}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", {63'd0, regRdValid}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", {16'd0, chStartAddr[0]}, 64'd0);
    chk("R1", {16'd0, chLen[1]}, 64'd0);
    chk("R1", {62'd0, chCmdReq}, 64'd0);
    chk("R1", {50'd0, chRate}, 64'd0);
    chk("R1", {32'd0, timeoutSet}, 64'd0);
    chk("R1", {63'd0, |ctmSubmQ}, 64'd0);
    chk("R1", {63'd0, regRdValid}, 64'd0);

    for (int i = 0; i < 15; i++) doRead(RD_VEC[i][47:32], RD_VEC[i][31:0], {8'd0, RD_VEC[i][63:48]});
    doRead(16'h4020, 32'hC700_0008, "R10");

    // R2: channel control fields
    doWrite(16'h0000, 32'h1234_5678);
    doWrite(16'h0004, 32'hFFFF_ABCD);
    chk("R2", {16'd0, chStartAddr[0]}, {16'd0, 48'hABCD_1234_5678});
    doWrite(16'h0008, 32'h0000_0400);
    doWrite(16'h000C, 32'h0000_0001);
    chk("R2", {16'd0, chLen[0]}, {16'd0, 48'h0001_0000_0400});
    doWrite(16'h0014, 32'hFFFF_FFF4);
    chk("R2", {61'd0, chPattern[0]}, 64'd4);
    doWrite(16'h0018, 32'd100);
    chk("R2", {57'd0, chRate[0]}, 64'd100);
    doWrite(16'h0218, 32'd40);
    chk("R2", {57'd0, chRate[1]}, 64'd40);
    chk("R2", {57'd0, chRate[0]}, 64'd100);
    doWrite(16'h0200, 32'hCAFE_0001);
    chk("R2", {16'd0, chStartAddr[1]}, {16'd0, 48'h0000_CAFE_0001});
    chk("R2", {16'd0, chStartAddr[0]}, {16'd0, 48'hABCD_1234_5678});
    doRead(16'h0000, 32'h0, "R8");

    // R3 / R4: channel 0 commands
    doWrite(16'h0010, 32'd3);
    chk("R3", {62'd0, chCmdReq}, 64'd1);
    chk("R3", {61'd0, chCmdCode[0]}, 64'd3);
    @(negedge clk);
    chk("R3", {62'd0, chCmdReq}, 64'd0);
    doWrite(16'h0010, 32'd5);
    chk("R4", {62'd0, chCmdReq}, 64'd0);
    chk("R4", {61'd0, chCmdCode[0]}, 64'd3);
    doWrite(16'h0010, 32'd7);
    chk("R4", {62'd0, chCmdReq}, 64'd0);
    chk("R4", {61'd0, chCmdCode[0]}, 64'd3);
    doWrite(16'h0010, 32'd4);
    chk("R3", {62'd0, chCmdReq}, 64'd1);
    chk("R3", {61'd0, chCmdCode[0]}, 64'd4);

    // R5: channel 1 restricted to write/read
    doWrite(16'h0210, 32'd0);
    chk("R5", {62'd0, chCmdReq}, 64'd0);
    doWrite(16'h0210, 32'd6);
    chk("R5", {62'd0, chCmdReq}, 64'd0);
    chk("R5", {61'd0, chCmdCode[1]}, 64'd0);
    doWrite(16'h0210, 32'd2);
    chk("R5", {62'd0, chCmdReq}, 64'd2);
    chk("R5", {61'd0, chCmdCode[1]}, 64'd2);
    @(negedge clk);
    chk("R5", {62'd0, chCmdReq}, 64'd0);
    doWrite(16'h0210, 32'd3);
    chk("R5", {62'd0, chCmdReq}, 64'd2);
    chk("R5", {61'd0, chCmdCode[1]}, 64'd3);

    // R9 / R10: memory windows
    doWrite(16'h2010, 32'h0000_0055);
    chk("R9", {63'd0, sawCtmWr}, 64'd0);
    doWrite(16'h4024, 32'hA5A5_0009);
    chk("R10", {63'd0, sawCtmWr}, 64'd1);
    chk("R10", {32'd0, sawCtmData}, 64'hA5A5_0009);
    chk("R10", {53'd0, sawMemAddr}, 64'd9);

    // R11: queues
    doWrite(16'h603C, 32'hDEAD_0015);
    doWrite(16'h6004, 32'hBEEF_0001);
    chk("R11", {32'd0, ctmSubmQ[15]}, 64'hDEAD_0015);
    chk("R11", {32'd0, ctmSubmQ[1]}, 64'hBEEF_0001);
    chk("R11", {32'd0, ctmSubmQ[0]}, 64'd0);
    doWrite(16'h6100, 32'h0000_0077);
    chk("R11", {32'd0, ctmSubmQ[0]}, 64'd0);
    chk("R11", {32'd0, ctmSubmQ[1]}, 64'hBEEF_0001);
    doRead(16'h6100, 32'hC000_0000, "R11");

    // R12: shared area
    doWrite(16'h8000, 32'h0001_0000);
    chk("R12", {32'd0, timeoutSet}, 64'h0001_0000);
    doWrite(16'h8100, 32'h0000_FFFF);
    chk("R12", {32'd0, timeoutSet}, 64'h0001_0000);

    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule